// File: doc/BRIEF.md
# CAN Nominal Bit Timing Generator

This block turns the system clock into time-quantum ticks through a programmable prescaler. It then walks every nominal bit through four segments: a one-quantum synchronization slot, the propagation segment, phase segment 1 and phase segment 2. It raises a one-cycle strobe at the sample point, where phase 1 ends, and another at the bit boundary, where phase 2 ends. The bus level seen at the sample point is held as the received bit value. Triple sampling and frame handling live elsewhere.

The generator follows the bus edges. While the frame logic reports the bus as idle, a recessive-to-dominant edge restarts the bit. The restart point is the end of the synchronization slot, so the propagation segment begins at once. Outside idle, such an edge lengthens phase 1 or shortens phase 2 by the measured phase error. The change is capped by the programmed jump width, and only one adjustment is allowed per bit. A configuration that breaks the timing rules is reported as invalid, and while it is applied the generator stays parked.

Top module: `can_bit_timer`

## Requirements
- R1: With a valid configuration, `tq_tick_o` pulses for one clock every `brp_i`+1 clocks; after a bit boundary the first tick comes `brp_i`+1 clocks later.
- R2: Segments run in the order sync, propagation, phase 1, phase 2, and then wrap to sync. `seg_o` encodes them as 0 sync, 1 propagation, 2 phase 1, 3 phase 2. Sync always lasts one quantum.
- R3: With no bus edges, let B be `brp_i`. `sample_o` pulses (1+prop+ph1)×(B+1) clocks after a bit boundary, and `bit_end_o` pulses (1+prop+ph1+ph2)×(B+1) clocks after it. Both strobes coincide with a quantum tick.
- R4: `bit_val_o` resets to 1 (recessive). At each `sample_o` it takes the value of `rx_i` in that cycle and holds it until the next sample.
- R5: A configuration is valid only when all of these hold: prop, ph1 and ph2 are each non-zero; sjw lies from 1 to 4; sjw is at most ph1 and at most ph2; and 1+prop+ph1+ph2 lies from 8 to 25. Otherwise `cfg_ok_o` is 0, no tick or strobe is issued, and the generator is held at sync with its quantum counter cleared.
- R6: With `idle_i` high, a falling edge on `rx_i` (1 then 0 in consecutive cycles) restarts the prescaler and enters the propagation segment. The sample point then falls (prop+ph1)×(B+1) clocks after that edge, and the boundary falls (prop+ph1+ph2)×(B+1) clocks after it.
- R7: With `idle_i` low, a falling edge seen in propagation quantum q (0-based) has error q+1. One seen in phase-1 quantum q has error prop+1+q. Either one lengthens phase 1 by min(error, sjw) quanta.
- R8: With `idle_i` low, a falling edge seen in phase-2 quantum q has error ph2−q−1 (0 if negative). It shortens phase 2 by min(error, sjw). When the error is at most sjw, the bit ends at the end of the current quantum.
- R9: Rising edges never adjust timing, and a falling edge during sync does not either. After the first adjustment in a bit, further falling edges in that bit are ignored.
- R10: For the system clock frequency set as a checker parameter, a valid configuration gives a bit time of at least 1 µs in clocks. The default is 8 MHz, which makes the minimum 8 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| brp_i | input | PRESC_W | Prescaler; quantum = brp_i+1 clocks |
| prop_len_i | input | SEG_W | Propagation segment length in quanta |
| ph1_len_i | input | SEG_W | Phase 1 length in quanta |
| ph2_len_i | input | SEG_W | Phase 2 length in quanta |
| sjw_i | input | SJW_W | Resynchronization jump width in quanta |
| idle_i | input | 1 | Bus idle: falling edges hard-synchronize |
| rx_i | input | 1 | Received bus level, 1 = recessive |
| cfg_ok_o | output | 1 | Configuration valid |
| tq_tick_o | output | 1 | Time-quantum tick |
| seg_o | output | 2 | Current segment code |
| sample_o | output | 1 | Sample-point strobe |
| bit_end_o | output | 1 | Bit-boundary strobe |
| bit_val_o | output | 1 | Bit value captured at the last sample point |

## Verification
The bench aims falling edges at chosen quanta of a bit. An edge early in propagation and one at the start of phase 1 test the error measure: a generator that measured error from the wrong origin, or skipped the jump-width cap, would move the sample point by the wrong number of quanta. An edge at the start of phase 2 must end the bit one quantum later. A design that let the shortened length fall below the elapsed count would run on past the boundary. Edges inside sync, rising edges and a second falling edge in the same bit must leave the timing untouched, or the bit would stretch. The configuration walk covers the 8- and 25-quantum limits, sums one past each limit, and jump widths above a phase length. A checker that was off by one at a limit would accept a bad setting or park a good one.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PROP = 2'd1,
    SEG_PH1  = 2'd2,
    SEG_PH2  = 2'd3
  } seg_e;

  localparam int unsigned BIT_TQ_MIN = 8;
  localparam int unsigned BIT_TQ_MAX = 25;
  localparam int unsigned SJW_MAX    = 4;

  function automatic seg_e seg_next(input seg_e s);
    case (s)
      SEG_SYNC: seg_next = SEG_PROP;
      SEG_PROP: seg_next = SEG_PH1;
      SEG_PH1:  seg_next = SEG_PH2;
      default:  seg_next = SEG_SYNC;
    endcase
  endfunction
endpackage

// File: rtl/can_bt_cfg.sv
module can_bt_cfg #(
  parameter int SEG_W = 4,
  parameter int SJW_W = 3
) (
  input  logic [SEG_W-1:0] prop_len_i,
  input  logic [SEG_W-1:0] ph1_len_i,
  input  logic [SEG_W-1:0] ph2_len_i,
  input  logic [SJW_W-1:0] sjw_i,
  output logic             ok_o
);
  import can_bt_pkg::*;

  localparam int SUM_W = (SEG_W > SJW_W ? SEG_W : SJW_W) + 3;

  logic [SUM_W-1:0] prop_x, ph1_x, ph2_x, sjw_x, total;

  always_comb begin
    prop_x = SUM_W'(prop_len_i);
    ph1_x  = SUM_W'(ph1_len_i);
    ph2_x  = SUM_W'(ph2_len_i);
    sjw_x  = SUM_W'(sjw_i);
    total  = SUM_W'(1) + prop_x + ph1_x + ph2_x;
    ok_o   = (prop_x != '0) && (ph1_x != '0) && (ph2_x != '0) &&
             (sjw_x != '0) && (sjw_x <= SUM_W'(SJW_MAX)) &&
             (sjw_x <= ph1_x) && (sjw_x <= ph2_x) &&
             (total >= SUM_W'(BIT_TQ_MIN)) && (total <= SUM_W'(BIT_TQ_MAX));
  end
endmodule

// File: rtl/can_bt_presc.sv
module can_bt_presc #(
  parameter int PRESC_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               restart_i,
  input  logic [PRESC_W-1:0] brp_i,
  output logic               tick_o
);
  logic [PRESC_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == brp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (!en_i || restart_i || tick_o) cnt_q <= '0;
    else                                  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/can_bt_edge.sv
module can_bt_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic fall_o
);
  logic rx_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_d <= 1'b1;
    else         rx_d <= rx_i;
  end

  // recessive (1) to dominant (0)
  assign fall_o = rx_d & ~rx_i;
endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq #(
  parameter int SEG_W = 4,
  parameter int SJW_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             hsync_i,
  input  logic             fall_i,
  input  logic             idle_i,
  input  logic [SEG_W-1:0] prop_len_i,
  input  logic [SEG_W-1:0] ph1_len_i,
  input  logic [SEG_W-1:0] ph2_len_i,
  input  logic [SJW_W-1:0] sjw_i,
  output logic [1:0]       seg_o,
  output logic             sample_o,
  output logic             bit_end_o
);
  import can_bt_pkg::*;

  // room for phase 1 plus the widest jump
  localparam int QC_W = (SEG_W > SJW_W ? SEG_W : SJW_W) + 2;

  seg_e            seg_q;
  logic [QC_W-1:0] qcnt_q, ext_q, shr_q;
  logic [QC_W-1:0] ext_n, shr_n, err, adj, seg_len;
  logic [QC_W-1:0] prop_x, ph1_x, ph2_x, sjw_x;
  logic            rs_q, rs_go, last, step;

  assign prop_x = QC_W'(prop_len_i);
  assign ph1_x  = QC_W'(ph1_len_i);
  assign ph2_x  = QC_W'(ph2_len_i);
  assign sjw_x  = QC_W'(sjw_i);

  assign rs_go = en_i && fall_i && !idle_i && !rs_q && (seg_q != SEG_SYNC);

  always_comb begin
    unique case (seg_q)
      SEG_PROP: err = qcnt_q + 1'b1;
      SEG_PH1:  err = prop_x + qcnt_q + 1'b1;
      SEG_PH2:  err = ((qcnt_q + 1'b1) >= ph2_x) ? '0 : (ph2_x - qcnt_q - 1'b1);
      default:  err = '0;
    endcase
    adj   = (err < sjw_x) ? err : sjw_x;
    ext_n = ext_q;
    shr_n = shr_q;
    if (rs_go) begin
      if (seg_q == SEG_PH2) shr_n = adj;
      else                  ext_n = adj;
    end
    unique case (seg_q)
      SEG_SYNC: seg_len = QC_W'(1);
      SEG_PROP: seg_len = prop_x;
      SEG_PH1:  seg_len = ph1_x + ext_n;
      default:  seg_len = ph2_x - shr_n;
    endcase
  end

  // >= keeps the count bounded if a length drops under it
  assign last      = (qcnt_q + 1'b1) >= seg_len;
  assign step      = tick_i && !hsync_i;
  assign sample_o  = step && last && (seg_q == SEG_PH1);
  assign bit_end_o = step && last && (seg_q == SEG_PH2);
  assign seg_o     = seg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q  <= SEG_SYNC;
      qcnt_q <= '0;
      ext_q  <= '0;
      shr_q  <= '0;
      rs_q   <= 1'b0;
    end else if (!en_i) begin
      seg_q  <= SEG_SYNC;
      qcnt_q <= '0;
      ext_q  <= '0;
      shr_q  <= '0;
      rs_q   <= 1'b0;
    end else if (hsync_i) begin
      seg_q  <= SEG_PROP;
      qcnt_q <= '0;
      ext_q  <= '0;
      shr_q  <= '0;
      rs_q   <= 1'b0;
    end else begin
      ext_q <= ext_n;
      shr_q <= shr_n;
      if (rs_go) rs_q <= 1'b1;
      if (step) begin
        if (last) begin
          qcnt_q <= '0;
          seg_q  <= seg_next(seg_q);
          if (seg_q == SEG_PH2) begin
            ext_q <= '0;
            shr_q <= '0;
            rs_q  <= 1'b0;
          end
        end else begin
          qcnt_q <= qcnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int PRESC_W = 6,
  parameter int SEG_W   = 4,
  parameter int SJW_W   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PRESC_W-1:0] brp_i,
  input  logic [SEG_W-1:0]   prop_len_i,
  input  logic [SEG_W-1:0]   ph1_len_i,
  input  logic [SEG_W-1:0]   ph2_len_i,
  input  logic [SJW_W-1:0]   sjw_i,
  input  logic               idle_i,
  input  logic               rx_i,
  output logic               cfg_ok_o,
  output logic               tq_tick_o,
  output logic [1:0]         seg_o,
  output logic               sample_o,
  output logic               bit_end_o,
  output logic               bit_val_o
);
  logic fall, hsync, bit_val_q;

  can_bt_cfg #(.SEG_W(SEG_W), .SJW_W(SJW_W)) u_cfg (
    .prop_len_i (prop_len_i),
    .ph1_len_i  (ph1_len_i),
    .ph2_len_i  (ph2_len_i),
    .sjw_i      (sjw_i),
    .ok_o       (cfg_ok_o)
  );

  can_bt_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rx_i   (rx_i),
    .fall_o (fall)
  );

  assign hsync = cfg_ok_o && idle_i && fall;

  can_bt_presc #(.PRESC_W(PRESC_W)) u_presc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (cfg_ok_o),
    .restart_i (hsync),
    .brp_i     (brp_i),
    .tick_o    (tq_tick_o)
  );

  can_bt_seq #(.SEG_W(SEG_W), .SJW_W(SJW_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (cfg_ok_o),
    .tick_i     (tq_tick_o),
    .hsync_i    (hsync),
    .fall_i     (fall),
    .idle_i     (idle_i),
    .prop_len_i (prop_len_i),
    .ph1_len_i  (ph1_len_i),
    .ph2_len_i  (ph2_len_i),
    .sjw_i      (sjw_i),
    .seg_o      (seg_o),
    .sample_o   (sample_o),
    .bit_end_o  (bit_end_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       bit_val_q <= 1'b1;
    else if (sample_o) bit_val_q <= rx_i;
  end

  assign bit_val_o = bit_val_q;
endmodule

// File: rtl/can_bit_timer_chk.sv
module can_bit_timer_chk #(
  parameter int PRESC_W = 6,
  parameter int SEG_W   = 4,
  parameter int SJW_W   = 3,
  parameter int CLK_HZ  = 8_000_000
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [PRESC_W-1:0] brp_i,
  input logic [SEG_W-1:0]   prop_len_i,
  input logic [SEG_W-1:0]   ph1_len_i,
  input logic [SEG_W-1:0]   ph2_len_i,
  input logic               rx_i,
  input logic               cfg_ok_o,
  input logic               tq_tick_o,
  input logic [1:0]         seg_o,
  input logic               sample_o,
  input logic               bit_end_o,
  input logic               bit_val_o
);
  localparam int MIN_BIT_CLKS = CLK_HZ / 1_000_000;

  int bit_clks;
  always_comb
    bit_clks = (1 + int'(prop_len_i) + int'(ph1_len_i) + int'(ph2_len_i)) * (int'(brp_i) + 1);

  a_r1_tick_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tq_tick_o && brp_i != '0) |=> !tq_tick_o);

  a_r2_seg_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cfg_ok_o) && cfg_ok_o && seg_o != $past(seg_o)) |->
      (seg_o == $past(seg_o) + 2'd1) || (seg_o == 2'd1));

  a_r3_strobe_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_o || bit_end_o) |-> tq_tick_o);

  a_r3_end_to_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_end_o |=> (seg_o == 2'd0) || (seg_o == 2'd1));

  a_r4_bit_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> bit_val_o == $past(rx_i));

  a_r5_quiet_when_bad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_ok_o |-> !tq_tick_o && !sample_o && !bit_end_o);

  a_r5_park_when_bad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_ok_o |=> seg_o == 2'd0);

  a_r10_min_bit_time: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_ok_o |-> bit_clks >= MIN_BIT_CLKS);
endmodule

bind can_bit_timer can_bit_timer_chk #(
  .PRESC_W (PRESC_W),
  .SEG_W   (SEG_W),
  .SJW_W   (SJW_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .brp_i      (brp_i),
  .prop_len_i (prop_len_i),
  .ph1_len_i  (ph1_len_i),
  .ph2_len_i  (ph2_len_i),
  .rx_i       (rx_i),
  .cfg_ok_o   (cfg_ok_o),
  .tq_tick_o  (tq_tick_o),
  .seg_o      (seg_o),
  .sample_o   (sample_o),
  .bit_end_o  (bit_end_o),
  .bit_val_o  (bit_val_o)
);

// File: tb/can_bit_timer_test.sv
module can_bit_timer_test;
  localparam int MIN_BIT_CLKS = 8;
  localparam int NV = 11;
  // brp, prop, ph1, ph2, sjw, valid
  localparam int VEC [NV][6] = '{
    '{0, 1, 3, 3, 1, 1},
    '{2, 2, 3, 3, 2, 1},
    '{1, 8, 8, 8, 4, 1},
    '{3, 4, 2, 2, 2, 1},
    '{0, 1, 3, 2, 1, 0},
    '{0, 8, 8, 9, 4, 0},
    '{0, 2, 3, 3, 4, 0},
    '{0, 2, 3, 3, 0, 0},
    '{0, 0, 4, 4, 1, 0},
    '{5, 3, 3, 2, 2, 1},
    '{0, 2, 5, 2, 3, 0}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] brp_i = '0;
  logic [3:0] prop_len_i = '0, ph1_len_i = '0, ph2_len_i = '0;
  logic [2:0] sjw_i = '0;
  logic       idle_i = 1'b0, rx_i = 1'b1;
  logic       cfg_ok_o, tq_tick_o, sample_o, bit_end_o, bit_val_o;
  logic [1:0] seg_o;

  int checks = 0;
  int fails = 0;

  always #5 clk_i = ~clk_i;

  can_bit_timer uut (
    .clk_i, .rst_ni, .brp_i, .prop_len_i, .ph1_len_i, .ph2_len_i, .sjw_i,
    .idle_i, .rx_i, .cfg_ok_o, .tq_tick_o, .seg_o, .sample_o, .bit_end_o, .bit_val_o
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input int b, input int p, input int a, input int c, input int s);
    @(negedge clk_i);
    prop_len_i = '0; ph1_len_i = '0; ph2_len_i = '0; sjw_i = '0;
    @(negedge clk_i);
    brp_i = 6'(b); prop_len_i = 4'(p); ph1_len_i = 4'(a); ph2_len_i = 4'(c); sjw_i = 3'(s);
    @(negedge clk_i);
  endtask

  task automatic wait_end();
    int n = 0;
    do begin
      @(negedge clk_i);
      n++;
    end while (!bit_end_o && n < 2000);
  endtask

  // called at the negedge where bit_end_o is high; i counts negedges after it
  task automatic run_bit(input int kf, input int kr, input int kf2,
                         output int t_smp, output int t_end, output int ticks, output int t_tick1);
    t_smp = 0; t_end = 0; ticks = 0; t_tick1 = 0;
    for (int i = 1; i <= 400; i++) begin
      @(negedge clk_i);
      if (tq_tick_o) begin
        ticks++;
        if (t_tick1 == 0) t_tick1 = i;
      end
      if (sample_o && t_smp == 0) t_smp = i;
      if (bit_end_o) begin
        t_end = i;
        break;
      end
      if (i == kf)  rx_i = 1'b0;
      if (i == kr)  rx_i = 1'b1;
      if (i == kf2) rx_i = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int smp, tend, tk, t1, b, q, e;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R5 reset cfg_ok", int'(cfg_ok_o), 0);
    chk("R2 reset seg", int'(seg_o), 0);
    chk("R4 reset bit_val", int'(bit_val_o), 1);
    chk("R5 reset tick", int'(tq_tick_o), 0);

    // configuration table walk
    for (int v = 0; v < NV; v++) begin
      set_cfg(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4]);
      chk($sformatf("R5 cfg_ok vec %0d", v), int'(cfg_ok_o), VEC[v][5]);
      if (VEC[v][5] == 1) begin
        b = VEC[v][0] + 1;
        q = 1 + VEC[v][1] + VEC[v][2] + VEC[v][3];
        wait_end();
        run_bit(0, 0, 0, smp, tend, tk, t1);
        chk($sformatf("R3 bit end vec %0d", v), tend, q * b);
        chk($sformatf("R3 sample vec %0d", v), smp, (1 + VEC[v][1] + VEC[v][2]) * b);
        chk($sformatf("R2 quanta per bit vec %0d", v), tk, q);
        chk($sformatf("R1 first tick vec %0d", v), t1, b);
        chk($sformatf("R10 min bit clocks vec %0d", v), int'(tend >= MIN_BIT_CLKS), 1);
      end else begin
        tk = 0;
        e = 0;
        for (int i = 0; i < 40; i++) begin
          @(negedge clk_i);
          if (tq_tick_o || sample_o || bit_end_o) tk++;
          if (seg_o != 2'd0) e++;
        end
        chk($sformatf("R5 no ticks vec %0d", v), tk, 0);
        chk($sformatf("R5 parked vec %0d", v), e, 0);
      end
    end

    // resync scenarios: brp 1, prop 2, ph1 3, ph2 3, sjw 2 (9 quanta, 18 clocks)
    set_cfg(1, 2, 3, 3, 2);
    wait_end();
    run_bit(0, 0, 0, smp, tend, tk, t1);
    chk("R3 plain end", tend, 18);
    chk("R4 bit_val recessive", int'(bit_val_o), 1);

    run_bit(7, 0, 0, smp, tend, tk, t1);  // phase 1 q0: error 3, capped to 2
    chk("R7 ph1 edge sample", smp, 16);
    chk("R7 ph1 edge end", tend, 22);
    chk("R4 bit_val dominant", int'(bit_val_o), 0);
    rx_i = 1'b1;

    run_bit(3, 0, 0, smp, tend, tk, t1);  // prop q0: error 1
    chk("R7 prop edge sample", smp, 14);
    chk("R7 prop edge end", tend, 20);
    rx_i = 1'b1;

    run_bit(13, 0, 0, smp, tend, tk, t1); // phase 2 q0: error 2 <= sjw
    chk("R8 ph2 edge sample", smp, 12);
    chk("R8 ph2 edge end", tend, 14);
    rx_i = 1'b1;

    run_bit(1, 7, 0, smp, tend, tk, t1);  // fall in sync, rise in phase 1
    chk("R9 sync and rising edge end", tend, 18);
    rx_i = 1'b1;

    run_bit(3, 5, 7, smp, tend, tk, t1);  // second fall in same bit ignored
    chk("R9 one resync per bit end", tend, 20);
    rx_i = 1'b1;

    // hard synchronization while idle
    repeat (5) @(negedge clk_i);
    idle_i = 1'b1;
    @(negedge clk_i);
    rx_i = 1'b0;
    smp = 0; tend = 0;
    for (int i = 1; i <= 100; i++) begin
      @(negedge clk_i);
      if (sample_o && smp == 0) smp = i;
      if (bit_end_o) begin
        tend = i;
        break;
      end
    end
    chk("R6 hard sync sample", smp, 10);
    chk("R6 hard sync end", tend, 16);
    chk("R4 bit_val after hard sync", int'(bit_val_o), 0);
    rx_i = 1'b1;
    idle_i = 1'b0;

    @(negedge clk_i);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule